// File: doc/BRIEF.md
# Return-Address Stack with Fill-Watermark Interrupt

This block is a last-in first-out hardware stack for a processor core. It holds return addresses pushed on subroutine calls and interrupt entry. The default build stores 33 words of 16 bits. Separate push and pop strobes drive it. The current top entry is always visible on an output, next to the number of occupied entries and to empty and full flags.

To let software spill entries to memory, or refill them, before the stack runs dry or overflows, the block drives a level-sensitive interrupt request. The request is recomputed every cycle from the occupancy count. It is high while the count is below a low watermark (3 by default) or above a high watermark (28 by default). A push into a full stack is dropped and a pop from an empty stack is refused. Each case sets its own sticky flag, which only reset clears. The same block, with its parameters changed, serves as an 8-entry loop stack or a 16-entry status stack.

A three-state controller tracks occupancy:
- **ST_EMPTY**: no entries.
- **ST_PARTIAL**: between one and DEPTH-1 entries.
- **ST_FULL**: DEPTH entries.

The transitions are:
- **FILL_FIRST**: ST_EMPTY to ST_PARTIAL on a push, or on a push with a pop.
- **FILL_LAST**: ST_PARTIAL to ST_FULL on a push that reaches DEPTH.
- **DRAIN_FIRST**: ST_FULL to ST_PARTIAL on a pop.
- **DRAIN_LAST**: ST_PARTIAL to ST_EMPTY on a pop from one entry.

In every other case the state holds.

Top module: `hw_ret_stack`

## Requirements
- R1: After reset the stack reports a level of 0, empty high, full low, both sticky flags low, the level interrupt high and a top value of zero.
- R2: A push alone on a stack that is not full writes push_data as the new top and raises the level by one, both visible one cycle later.
- R3: A pop alone on a stack that is not empty lowers the level by one, and top_data then shows the entry pushed before the removed one (last in, first out).
- R4: A push and a pop in the same cycle on a stack that is not empty overwrite the top entry with push_data and leave the level unchanged; no flag is set.
- R5: A push alone on a full stack is ignored: the level and top_data stay as they were, and the overflow flag goes high and stays high until reset.
- R6: A pop alone on an empty stack leaves the level at 0 with top_data equal to zero, and sets the underflow flag, which stays high until reset.
- R7: level_irq is high whenever the level is below LOW_MARK (levels 0, 1 and 2 by default).
- R8: level_irq is high whenever the level is above HIGH_MARK (levels 29 to 33 by default), and low for every level from LOW_MARK to HIGH_MARK inclusive.
- R9: empty is high exactly when the level is 0, full is high exactly when the level is DEPTH, and the level never exceeds DEPTH.
- R10: A push and a pop in the same cycle on an empty stack store push_data as the only entry (level 1) and set the underflow flag.
- R11: A cycle with neither strobe leaves the level, top_data and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Push strobe |
| pop_en | input | 1 | Pop strobe |
| push_data | input | WIDTH | Word to push |
| top_data | output | WIDTH | Current top entry, zero when empty |
| level | output | clog2(DEPTH+1) | Number of occupied entries |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |
| level_irq | output | 1 | Level below LOW_MARK or above HIGH_MARK |
| overflow | output | 1 | Sticky: a push hit a full stack |
| underflow | output | 1 | Sticky: a pop hit an empty stack |

## Verification
Every result of a strobe is due exactly one clock cycle after the strobe is sampled. On that edge the level, the flags and the storage all update. top_data, empty, full and level_irq then follow from those registers through combinational logic within the same cycle. The driver applies each strobe after a falling edge and queues the result a reference model predicts for it. The monitor takes that item off the queue one nanosecond after the next rising edge, so each comparison falls in the first cycle the result is due and before any later stimulus can change it.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } stk_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = 33,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output stk_state_e       state,
    output logic [LVL_W-1:0] level,
    output logic             wr_en,
    output logic [LVL_W-1:0] wr_addr,
    output logic             overflow,
    output logic             underflow
);

    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] ONE_L   = LVL_W'(1);
    localparam logic [LVL_W-1:0] ZERO_L  = '0;

    stk_op_e          op;
    stk_state_e       state_nxt;
    logic [LVL_W-1:0] level_nxt;
    logic             ovf_set;
    logic             udf_set;

    always_comb begin
        op = stk_op_e'({pop, push});
    end

    // next level, write strobe and error events per state
    always_comb begin
        level_nxt = level;
        wr_en     = 1'b0;
        wr_addr   = level;
        ovf_set   = 1'b0;
        udf_set   = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                unique case (op)
                    OP_PUSH: begin
                        wr_en     = 1'b1;
                        wr_addr   = ZERO_L;
                        level_nxt = ONE_L;
                    end
                    OP_SWAP: begin
                        wr_en     = 1'b1;
                        wr_addr   = ZERO_L;
                        level_nxt = ONE_L;
                        udf_set   = 1'b1;
                    end
                    OP_POP:  udf_set = 1'b1;
                    default: ;
                endcase
            end
            ST_PARTIAL: begin
                unique case (op)
                    OP_PUSH: begin
                        wr_en     = 1'b1;
                        wr_addr   = level;
                        level_nxt = level + 1'b1;
                    end
                    OP_POP:  level_nxt = level - 1'b1;
                    OP_SWAP: begin
                        wr_en   = 1'b1;
                        wr_addr = level - 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_FULL: begin
                unique case (op)
                    OP_PUSH: ovf_set = 1'b1;
                    OP_POP:  level_nxt = level - 1'b1;
                    OP_SWAP: begin
                        wr_en   = 1'b1;
                        wr_addr = level - 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // state follows the occupancy the cycle produces
    always_comb begin
        if (level_nxt == ZERO_L) begin
            state_nxt = ST_EMPTY;
        end else if (level_nxt == DEPTH_L) begin
            state_nxt = ST_FULL;
        end else begin
            state_nxt = ST_PARTIAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level     <= ZERO_L;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            level     <= level_nxt;
            overflow  <= overflow | ovf_set;
            underflow <= underflow | udf_set;
        end
    end

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level != DEPTH_L) |=> level == $past(level) + 1'b1); // R2
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level != ZERO_L) |=> level == $past(level) - 1'b1); // R3
    AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != ZERO_L) |=> $stable(level)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == DEPTH_L) |=> ($stable(level) && overflow)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == ZERO_L) |=> (level == ZERO_L && underflow)); // R6
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R6
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L); // R9
    AST_EMPTY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level == ZERO_L) |=> (level == ONE_L && underflow)); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(level)); // R11

endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
    parameter int DEPTH = 33,
    parameter int WIDTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [LVL_W-1:0] rd_level,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] entry [DEPTH];
    logic [LVL_W-1:0] rd_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == LVL_W'(g)) begin
                entry[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_idx = rd_level - 1'b1;
        if (rd_level == '0) begin
            rd_data = '0;
        end else begin
            rd_data = entry[rd_idx];
        end
    end

endmodule

// File: rtl/stk_watermark.sv
module stk_watermark #(
    parameter int LVL_W     = 6,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28
) (
    input  logic [LVL_W-1:0] level,
    output logic             irq
);

    localparam logic [LVL_W-1:0] LOW_L  = LVL_W'(LOW_MARK);
    localparam logic [LVL_W-1:0] HIGH_L = LVL_W'(HIGH_MARK);

    always_comb begin
        irq = (level < LOW_L) || (level > HIGH_L);
    end

endmodule

// File: rtl/hw_ret_stack.sv
module hw_ret_stack
    import stk_pkg::*;
#(
    parameter int DEPTH     = 33,
    parameter int WIDTH     = 16,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_en,
    input  logic                         pop_en,
    input  logic [WIDTH-1:0]             push_data,
    output logic [WIDTH-1:0]             top_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         full,
    output logic                         level_irq,
    output logic                         overflow,
    output logic                         underflow
);

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    stk_state_e       state;
    logic             wr_en;
    logic [LVL_W-1:0] wr_addr;

    stk_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_en),
        .pop       (pop_en),
        .state     (state),
        .level     (level),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .overflow  (overflow),
        .underflow (underflow)
    );

    stk_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LVL_W(LVL_W)) u_mem (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (push_data),
        .rd_level (level),
        .rd_data  (top_data)
    );

    stk_watermark #(.LVL_W(LVL_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_mark (
        .level (level),
        .irq   (level_irq)
    );

    always_comb begin
        empty = (state == ST_EMPTY);
        full  = (state == ST_FULL);
    end

    AST_EMPTY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0)); // R9
    AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        full == (level == DEPTH_L)); // R9
    AST_EMPTY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> top_data == '0); // R6
    AST_FULL_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_en && !pop_en) |=> $stable(top_data)); // R5

endmodule

// File: tb/hw_ret_stack_test.sv
`timescale 1ns/1ps
module hw_ret_stack_test;

    localparam int DEPTH = 33;
    localparam int WIDTH = 16;
    localparam int LOWM  = 3;
    localparam int HIGHM = 28;
    localparam int LW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_en = 1'b0;
    logic             pop_en = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic [WIDTH-1:0] top_data;
    logic [LW-1:0]    level;
    logic             empty, full, level_irq, overflow, underflow;

    always #2 clk = ~clk;

    hw_ret_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LOW_MARK(LOWM), .HIGH_MARK(HIGHM)) uut (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
        .push_data(push_data), .top_data(top_data), .level(level),
        .empty(empty), .full(full), .level_irq(level_irq),
        .overflow(overflow), .underflow(underflow)
    );

    typedef struct {
        string req;
        int    lvl;
        int    top;
        bit    irq;
        bit    emp;
        bit    ful;
        bit    ovf;
        bit    udf;
    } exp_t;

    exp_t exp_q[$];
    int   model[$];
    bit   m_ovf, m_udf;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    function automatic exp_t predict(string req);
        exp_t e;
        e.req = req;
        e.lvl = model.size();
        e.top = (model.size() > 0) ? model[model.size()-1] : 0;
        e.irq = (e.lvl < LOWM) || (e.lvl > HIGHM);
        e.emp = (e.lvl == 0);
        e.ful = (e.lvl == DEPTH);
        e.ovf = m_ovf;
        e.udf = m_udf;
        return e;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(exp_t e);
        chk(e.req, "level", int'(level), e.lvl);
        chk(e.req, "top_data", int'(top_data), e.top);
        chk(e.req, "level_irq", int'(level_irq), int'(e.irq));
        chk(e.req, "empty", int'(empty), int'(e.emp));
        chk(e.req, "full", int'(full), int'(e.ful));
        chk(e.req, "overflow", int'(overflow), int'(e.ovf));
        chk(e.req, "underflow", int'(underflow), int'(e.udf));
    endtask

    // driver: one call is one clock cycle of stimulus
    task automatic op(bit p, bit q, int d, string req);
        @(negedge clk);
        push_en   = p;
        pop_en    = q;
        push_data = WIDTH'(d);
        if (p && q) begin
            if (model.size() > 0) begin
                model[model.size()-1] = d & 16'hFFFF;
            end else begin
                model.push_back(d & 16'hFFFF);
                m_udf = 1'b1;
            end
        end else if (p) begin
            if (model.size() < DEPTH) model.push_back(d & 16'hFFFF);
            else m_ovf = 1'b1;
        end else if (q) begin
            if (model.size() > 0) void'(model.pop_back());
            else m_udf = 1'b1;
        end
        exp_q.push_back(predict(req));
    endtask

    task automatic do_reset();
        @(negedge clk);
        push_en = 1'b0;
        pop_en  = 1'b0;
        rst_n   = 1'b0;
        model.delete();
        m_ovf = 1'b0;
        m_udf = 1'b0;
        @(negedge clk);
        @(negedge clk);
        compare(predict("R1"));
        rst_n = 1'b1;
    endtask

    // monitor: result due one cycle after the strobe
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10: push and pop together on empty
        op(1, 1, 16'h1234, "R10");
        op(0, 0, 0, "R11");
        do_reset();
        // R6: pop on empty
        op(0, 1, 0, "R6");
        op(0, 1, 0, "R6");
        do_reset();
        // R2, R7, R8, R9: fill to the top
        for (int i = 0; i < DEPTH; i++) begin
            op(1, 0, 16'hA000 + i * 37, (i < LOWM) ? "R7" : ((i >= HIGHM) ? "R8" : "R2"));
        end
        op(0, 0, 0, "R9");
        // R5: push on full ignored
        op(1, 0, 16'hDEAD, "R5");
        op(0, 0, 0, "R5");
        // R4: swap at full
        op(1, 1, 16'hBEEF, "R4");
        // R3, R8, R7: drain
        for (int i = 0; i < DEPTH; i++) begin
            op(0, 1, 0, (i < 5) ? "R8" : ((i > DEPTH - 5) ? "R7" : "R3"));
        end
        op(0, 0, 0, "R9");
        // mixed pattern
        op(1, 0, 16'h0111, "R2");
        op(1, 0, 16'h0222, "R2");
        op(1, 1, 16'h0333, "R4");
        op(0, 0, 0, "R11");
        op(0, 1, 0, "R3");
        op(1, 0, 16'hFFFF, "R2");
        op(0, 1, 0, "R3");
        op(0, 1, 0, "R3");
        op(0, 1, 0, "R6");
        op(0, 0, 0, "R11");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule